// File: doc/BRIEF.md
# ECC DIMM Pair Resolver

This block takes a reported memory error for one chip-select and decides which DIMM holds it. A chip-select can serve a single DIMM or a lower/upper pair. The block answers with a 2-bit select: the lower DIMM, the upper DIMM, or both. It reaches that answer from four things:

- how many of the two DIMM slots are populated;
- the ECC mode in force;
- address bit 3 together with the lowest address bit that can be trusted;
- for symbol-based ECC, the position of the failing symbol.

The failing symbol is supplied already decoded, as a kind (data or check), its high bit index and a valid flag. Turning a syndrome into a symbol happens upstream.

A request is presented with a one-cycle strobe. The verdict appears one cycle later, together with a one-cycle valid pulse, and stays held until the next request. A verdict that cannot be resolved raises one of three error flags and drives the select to zero.

Top module: `dimm_pair_resolver`

## Requirements
- R1: The reserved ID value (all ones, 4'hF at default width) marks an empty slot. When both slot IDs equal it, no_dimm_o is 1 and dimm_sel_o is 2'b00.
- R2: When exactly one slot ID is populated, in either slot, dimm_sel_o is 2'b01 (DIMM1). This holds in both ECC modes and for any other input.
- R3: In 64/8 mode (ecc_mode_i = 0) with two DIMMs and valid_lo_i <= 3, address bit 3 decides the select. A 1 gives 2'b10 (DIMM2) and a 0 gives 2'b01 (DIMM1). This holds whether the error is correctable or not.
- R4: In 64/8 mode with two DIMMs and valid_lo_i > 3, insuff_res_o is 1 and dimm_sel_o is 2'b00.
- R5: In symbol mode (ecc_mode_i = 1) with two DIMMs, a correctable error and a valid symbol, the select depends on the symbol. It is 2'b01 for a data symbol (sym_is_check_i = 0) whose high bit is at most 63. It is also 2'b01 for a check symbol (sym_is_check_i = 1) whose high bit is at most 7. Every other symbol gives 2'b10.
- R6: In symbol mode with two DIMMs and an uncorrectable error, dimm_sel_o is 2'b11, whatever the symbol inputs are.
- R7: In symbol mode with two DIMMs, a correctable error and sym_valid_i = 0, synd_inv_o is 1 and dimm_sel_o is 2'b00.
- R8: Output timing and hold:
  - valid_o pulses in the cycle after each cycle in which req_i is high, and is low otherwise.
  - The verdict outputs change only in the cycle after a request and hold their value in between.
  - Reset clears every output to 0.
- R9: At most one error flag is high at a time, and whenever any flag is high dimm_sel_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; the other inputs are sampled while it is high |
| dimm1_id_i | input | ID_W | ID of the lower-slot DIMM; all ones means empty |
| dimm2_id_i | input | ID_W | ID of the upper-slot DIMM; all ones means empty |
| err_addr_i | input | ADDR_W | Address of the error |
| valid_lo_i | input | LSB_W | Index of the lowest trustworthy address bit |
| ecc_mode_i | input | 1 | 0 = 64/8 ECC, 1 = symbol ECC |
| correctable_i | input | 1 | 1 when the error is correctable |
| sym_valid_i | input | 1 | 1 when the decoded symbol descriptor is usable |
| sym_is_check_i | input | 1 | 1 = check symbol, 0 = data symbol |
| sym_hi_i | input | HI_W | High bit index of the failing symbol |
| valid_o | output | 1 | One-cycle pulse marking a new verdict |
| dimm_sel_o | output | 2 | 01 DIMM1, 10 DIMM2, 11 both, 00 on error |
| no_dimm_o | output | 1 | No populated DIMM behind the chip-select |
| insuff_res_o | output | 1 | Address resolution too coarse for 64/8 mode |
| synd_inv_o | output | 1 | Correctable symbol error with an invalid descriptor |

## Verification
Every verdict is registered once. The select, the three flags and valid_o are therefore due exactly one clock after the edge that samples req_i.

The bench drives each request at a falling edge and drops the strobe at the next falling edge. It compares all outputs at that same point, which is half a cycle after the registering edge.

Hold checks leave req_i low for one more cycle while the inputs change. They then confirm that valid_o is low and that the previous verdict is still unchanged.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_LO   = 2'b01,
    SEL_HI   = 2'b10,
    SEL_BOTH = 2'b11
  } dimm_sel_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       no_dimm;
    logic       insuff;
    logic       synd_inv;
  } verdict_t;
endpackage

// File: rtl/dpr_presence.sv
`timescale 1ns/1ps
module dpr_presence #(
  parameter int ID_W     = 4,
  parameter int N_SLOTS  = 2,
  localparam int CNT_W   = $clog2(N_SLOTS + 1)
) (
  input  logic [N_SLOTS-1:0][ID_W-1:0] ids_i,
  output logic [CNT_W-1:0]             count_o
);
  localparam logic [ID_W-1:0] EMPTY_ID = '1;

  logic [N_SLOTS-1:0] present;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign present[g] = (ids_i[g] != EMPTY_ID);
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < N_SLOTS; i++) count_o = count_o + CNT_W'(present[i]);
  end
endmodule

// File: rtl/dpr_wide_pick.sv
`timescale 1ns/1ps
module dpr_wide_pick
  import dpr_pkg::*;
#(
  parameter int LSB_W   = 6,
  parameter int SEL_BIT = 3
) (
  input  logic             addr_bit_i,
  input  logic [LSB_W-1:0] valid_lo_i,
  output logic [1:0]       sel_o,
  output logic             insuff_o
);
  localparam logic [LSB_W-1:0] SEL_BIT_L = LSB_W'(SEL_BIT);

  // halves are ECC-checked independently, so any error resolves if bit is known
  always_comb begin
    insuff_o = (valid_lo_i > SEL_BIT_L);
    if (insuff_o)        sel_o = SEL_NONE;
    else if (addr_bit_i) sel_o = SEL_HI;
    else                 sel_o = SEL_LO;
  end
endmodule

// File: rtl/dpr_symbol_pick.sv
`timescale 1ns/1ps
module dpr_symbol_pick
  import dpr_pkg::*;
#(
  parameter int HI_W      = 7,
  parameter int DATA_TOP  = 63,
  parameter int CHECK_TOP = 7
) (
  input  logic            correctable_i,
  input  logic            sym_valid_i,
  input  logic            is_check_i,
  input  logic [HI_W-1:0] hi_i,
  output logic [1:0]      sel_o,
  output logic            synd_inv_o
);
  localparam logic [HI_W-1:0] DATA_TOP_L  = HI_W'(DATA_TOP);
  localparam logic [HI_W-1:0] CHECK_TOP_L = HI_W'(CHECK_TOP);

  logic in_low_half;

  assign in_low_half = is_check_i ? (hi_i <= CHECK_TOP_L) : (hi_i <= DATA_TOP_L);

  always_comb begin
    synd_inv_o = 1'b0;
    if (!correctable_i) begin
      sel_o = SEL_BOTH;
    end else if (!sym_valid_i) begin
      sel_o      = SEL_NONE;
      synd_inv_o = 1'b1;
    end else begin
      sel_o = in_low_half ? SEL_LO : SEL_HI;
    end
  end
endmodule

// File: rtl/dimm_pair_resolver.sv
`timescale 1ns/1ps
module dimm_pair_resolver
  import dpr_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 40,
  parameter int LSB_W     = 6,
  parameter int HI_W      = 7,
  parameter int SEL_BIT   = 3,
  parameter int DATA_TOP  = 63,
  parameter int CHECK_TOP = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ID_W-1:0]   dimm1_id_i,
  input  logic [ID_W-1:0]   dimm2_id_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [LSB_W-1:0]  valid_lo_i,
  input  logic              ecc_mode_i,
  input  logic              correctable_i,
  input  logic              sym_valid_i,
  input  logic              sym_is_check_i,
  input  logic [HI_W-1:0]   sym_hi_i,
  output logic              valid_o,
  output logic [1:0]        dimm_sel_o,
  output logic              no_dimm_o,
  output logic              insuff_res_o,
  output logic              synd_inv_o
);
  localparam int N_SLOTS = 2;
  localparam int CNT_W   = $clog2(N_SLOTS + 1);

  logic [CNT_W-1:0] n_present;
  logic [1:0]       wide_sel, sym_sel;
  logic             wide_insuff, sym_inv;
  verdict_t         next_v, cur_v;

  dpr_presence #(.ID_W(ID_W), .N_SLOTS(N_SLOTS)) u_presence (
    .ids_i   ({dimm2_id_i, dimm1_id_i}),
    .count_o (n_present)
  );

  dpr_wide_pick #(.LSB_W(LSB_W), .SEL_BIT(SEL_BIT)) u_wide (
    .addr_bit_i (err_addr_i[SEL_BIT]),
    .valid_lo_i (valid_lo_i),
    .sel_o      (wide_sel),
    .insuff_o   (wide_insuff)
  );

  dpr_symbol_pick #(.HI_W(HI_W), .DATA_TOP(DATA_TOP), .CHECK_TOP(CHECK_TOP)) u_symbol (
    .correctable_i (correctable_i),
    .sym_valid_i   (sym_valid_i),
    .is_check_i    (sym_is_check_i),
    .hi_i          (sym_hi_i),
    .sel_o         (sym_sel),
    .synd_inv_o    (sym_inv)
  );

  always_comb begin
    next_v = '0;
    if (n_present == '0) begin
      next_v.no_dimm = 1'b1;
    end else if (n_present == CNT_W'(1)) begin
      next_v.sel = SEL_LO;
    end else if (!ecc_mode_i) begin
      next_v.sel    = wide_sel;
      next_v.insuff = wide_insuff;
    end else begin
      next_v.sel      = sym_sel;
      next_v.synd_inv = sym_inv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_v   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) cur_v <= next_v;
    end
  end

  assign dimm_sel_o   = cur_v.sel;
  assign no_dimm_o    = cur_v.no_dimm;
  assign insuff_res_o = cur_v.insuff;
  assign synd_inv_o   = cur_v.synd_inv;

  a_r8_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(dimm_sel_o) && $stable(no_dimm_o) && $stable(insuff_res_o)
                && $stable(synd_inv_o)));
  a_r9_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({no_dimm_o, insuff_res_o, synd_inv_o}));
  a_r9_sel_clear_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_dimm_o || insuff_res_o || synd_inv_o) |-> (dimm_sel_o == 2'b00));
  a_r1_empty_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (&dimm1_id_i) && (&dimm2_id_i)) |=> no_dimm_o);
  a_r3_wide_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ecc_mode_i) |=> (dimm_sel_o != 2'b11));
  a_r2_single_is_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((&dimm1_id_i) != (&dimm2_id_i))) |=> (dimm_sel_o == 2'b01));
endmodule

// File: tb/dimm_pair_resolver_tb.sv
`timescale 1ns/1ps
module dimm_pair_resolver_tb;
  localparam int ID_W = 4, ADDR_W = 40, LSB_W = 6, HI_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ID_W-1:0]   id1 = '0, id2 = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LSB_W-1:0]  vlo = '0;
  logic              mode = 1'b0, corr = 1'b0, svalid = 1'b0, is_chk = 1'b0;
  logic [HI_W-1:0]   hi = '0;
  logic              valid;
  logic [1:0]        sel;
  logic              nod, ins, sinv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dimm_pair_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .dimm1_id_i(id1), .dimm2_id_i(id2), .err_addr_i(addr), .valid_lo_i(vlo),
    .ecc_mode_i(mode), .correctable_i(corr), .sym_valid_i(svalid),
    .sym_is_check_i(is_chk), .sym_hi_i(hi),
    .valid_o(valid), .dimm_sel_o(sel), .no_dimm_o(nod),
    .insuff_res_o(ins), .synd_inv_o(sinv)
  );

  // expected {sel, no_dimm, insuff, synd_inv}, from the requirements
  function automatic logic [4:0] model();
    int n;
    n = (id1 != 4'hF) + (id2 != 4'hF);
    if (n == 0) return {2'b00, 3'b100};                       // R1
    if (n == 1) return {2'b01, 3'b000};                       // R2
    if (!mode) begin
      if (vlo > 3) return {2'b00, 3'b010};                    // R4
      return {(addr[3] ? 2'b10 : 2'b01), 3'b000};             // R3
    end
    if (!corr) return {2'b11, 3'b000};                        // R6
    if (!svalid) return {2'b00, 3'b001};                      // R7
    if ((!is_chk && hi <= 63) || (is_chk && hi <= 7)) return {2'b01, 3'b000};  // R5
    return {2'b10, 3'b000};
  endfunction

  function automatic string tag_of();
    int n;
    n = (id1 != 4'hF) + (id2 != 4'hF);
    if (n == 0) return "R1";
    if (n == 1) return "R2";
    if (!mode) return (vlo > 3) ? "R4" : "R3";
    if (!corr) return "R6";
    return svalid ? "R5" : "R7";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/sel/flags %b expected %b", tag, act, exp);
    end
  endtask

  // request at a falling edge, compare one falling edge later (R8 latency)
  task automatic apply();
    logic [4:0] e;
    string t;
    e = model();
    t = tag_of();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(t, {valid, sel, nod, ins, sinv}, {1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    logic [6:0] his [6] = '{7'd0, 7'd7, 7'd8, 7'd63, 7'd64, 7'd127};
    logic [5:0] vlos [5] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd63};
    repeat (3) @(negedge clk);
    check("R8 reset", {valid, sel, nod, ins, sinv}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", {valid, sel, nod, ins, sinv}, 6'b0);

    for (int ids = 0; ids < 4; ids++) begin
      for (int m = 0; m < 2; m++) begin
        for (int v = 0; v < 5; v++) begin
          for (int a = 0; a < 2; a++) begin
            for (int c = 0; c < 2; c++) begin
              for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 2; k++) begin
                  for (int h = 0; h < 6; h++) begin
                    id1 = ids[0] ? 4'd2 : 4'hF;
                    id2 = ids[1] ? 4'd9 : 4'hF;
                    mode = m[0]; vlo = vlos[v];
                    addr = {32'h0000_1234, 4'b0, a[0], 3'b101};
                    corr = c[0]; svalid = s[0]; is_chk = k[0]; hi = his[h];
                    @(negedge clk);
                    apply();
                  end
                end
              end
            end
          end
        end
      end
    end

    // R8: no request means no pulse and a held verdict, whatever the inputs do
    for (int i = 0; i < 4; i++) begin
      id1 = 4'd1; id2 = 4'd3; mode = 1'b1; corr = 1'b0;
      @(negedge clk);
      apply();
      held = {sel, nod, ins, sinv};
      id1 = 4'hF; id2 = 4'hF; mode = i[0]; vlo = 6'd9; corr = 1'b1;
      @(negedge clk);
      check("R8 hold", {valid, sel, nod, ins, sinv}, {1'b0, held});
      @(negedge clk);
      check("R8 hold2", {valid, sel, nod, ins, sinv}, {1'b0, held});
    end

    // R9 and R2: single DIMM in the upper slot still reports DIMM1
    id1 = 4'hF; id2 = 4'd5; mode = 1'b0; vlo = 6'd40; addr = '1;
    @(negedge clk);
    apply();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule